// File: doc/BRIEF.md
# Split-Half Word/Byte Arithmetic-Logic Unit

This unit is the execute stage of a small processor with four 16-bit general registers. Each cycle it takes an operation code, a size select, two operands and an immediate shift count, and one clock later it presents a result, a write enable for the register file and three condition flags (zero, overflow, equal) that conditional branches test. The register file, operand fetch and instruction sequencing sit outside the block.

Every two-operand operation (add, subtract, and, or, exclusive-or, compare) can work on the whole word or on just one byte of it. In a byte form only the chosen byte of operand A, which is the destination register's current value, is replaced. The other byte comes back unchanged, so the register file always writes a full word. Invert and the two logical shifts also offer word and byte forms. Byte swap and sign extend always act on the whole word. Compare subtracts and updates the flags, but it keeps the write enable low.

Top module: `split_alu`

## Requirements
- R1: Operation codes are fixed as follows: add=0, sub=1, and=2, or=3, xor=4, compare=5, invert=6, shift-left=7, shift-right=8, byte-swap=9, sign-extend=10, no-op=11. Codes 12 to 15 behave as no-op.
- R2: Add produces A+B and sub produces A-B, both modulo the operand width. Overflow is set when the result overflows as a two's-complement signed value.
- R3: And, or and xor produce their bitwise results and always clear overflow.
- R4: Size select 2'b11 picks the high byte and 2'b10 picks the low byte. Both 2'b00 and 2'b01 mean the full word. In a byte form for codes 0 to 8, the result holds the computed byte in the selected half and operand A's other byte unchanged.
- R5: In byte forms, zero and overflow come from the 8-bit result, and overflow is taken at bit 7.
- R6: Compare drives the write enable low. It forms the same subtraction, flags and result value as sub. Equal is set exactly when that subtraction is zero.
- R7: Invert returns the bitwise complement of A in the selected width.
- R8: Shifts are logical and fill with zeros. A count equal to or larger than the selected width gives zero.
- R9: Byte swap exchanges A's two bytes, whatever the size select.
- R10: Sign extend copies A bit 7 into bits 15:8 and keeps bits 7:0, whatever the size select.
- R11: No-op and unused codes give result 0, write enable 0 and all flags clear. Every other code drives write enable high, except compare.
- R12: Outputs are registered and reflect the inputs one clock earlier. Synchronous reset clears the result, the write enable and all flags. Equal is clear for every operation other than compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| sel_i | input | 2 | Size select: word, low byte or high byte |
| a_i | input | 16 | Operand A, also the destination's current value |
| b_i | input | 16 | Operand B |
| shamt_i | input | 8 | Immediate shift count |
| result_o | output | 16 | Full word to write back |
| wr_en_o | output | 1 | Register write enable |
| zero_o | output | 1 | Result (of selected width) is zero |
| ovf_o | output | 1 | Signed overflow |
| eq_o | output | 1 | Compare found operands equal |

## Verification
The block has a single register stage and no state beyond it. Any fault therefore shows on the outputs in the cycle after the offending input, and nothing carries into later operations. A wrong byte-lane choice shows up as a corrupted pass-through byte or as flags taken from the wrong width. Sweeping every code against every size select, with carry, sign-boundary and equal-operand values and with shift counts past both widths, makes such faults appear on the very next sample.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_CMP  = 4'd5,
    OP_INV  = 4'd6,
    OP_SHL  = 4'd7,
    OP_SHR  = 4'd8,
    OP_SWAB = 4'd9,
    OP_SEXT = 4'd10,
    OP_NOP  = 4'd11
  } alu_op_e;

  typedef enum logic [1:0] {
    SZ_WORD     = 2'b00,
    SZ_WORD_ALT = 2'b01,
    SZ_LOW      = 2'b10,
    SZ_HIGH     = 2'b11
  } alu_size_e;

endpackage

// File: rtl/alu_byte_pick.sv
module alu_byte_pick #(
  parameter int W = 16
) (
  input  logic [W-1:0]   word_i,
  input  logic           hi_i,
  output logic [W/2-1:0] lane_o
);
  localparam int H = W / 2;

  assign lane_o = hi_i ? word_i[W-1:H] : word_i[H-1:0];
endmodule

// File: rtl/alu_byte_merge.sv
module alu_byte_merge #(
  parameter int W = 16
) (
  input  logic [W-1:0]   dest_i,
  input  logic [W/2-1:0] lane_i,
  input  logic           hi_i,
  output logic [W-1:0]   word_o
);
  localparam int H = W / 2;

  // the unselected half always comes from the destination value
  assign word_o = hi_i ? {lane_i, dest_i[H-1:0]} : {dest_i[W-1:H], lane_i};
endmodule

// File: rtl/alu_arith.sv
module alu_arith
  import alu_pkg::*;
#(
  parameter int W   = 16,
  parameter int SHW = 8
) (
  input  logic [3:0]     op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [SHW-1:0] shamt_i,
  output logic [W-1:0]   res_o,
  output logic           zero_o,
  output logic           ovf_o
);
  localparam int H = W / 2;
  localparam logic [SHW:0] W_LIM = (SHW + 1)'(W);

  logic [W-1:0] sum, diff;
  logic         too_far;

  assign sum     = a_i + b_i;
  assign diff    = a_i - b_i;
  assign too_far = {1'b0, shamt_i} >= W_LIM;

  always_comb begin
    res_o = '0;
    ovf_o = 1'b0;
    case (op_i)
      OP_ADD: begin
        res_o = sum;
        ovf_o = (a_i[W-1] == b_i[W-1]) && (sum[W-1] != a_i[W-1]);
      end
      OP_SUB, OP_CMP: begin
        res_o = diff;
        ovf_o = (a_i[W-1] != b_i[W-1]) && (diff[W-1] != a_i[W-1]);
      end
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_INV:  res_o = ~a_i;
      OP_SHL:  res_o = too_far ? '0 : a_i << shamt_i;
      OP_SHR:  res_o = too_far ? '0 : a_i >> shamt_i;
      OP_SWAB: res_o = {a_i[H-1:0], a_i[W-1:H]};
      OP_SEXT: res_o = {{(W - H){a_i[H-1]}}, a_i[H-1:0]};
      default: res_o = '0;
    endcase
  end

  assign zero_o = (res_o == '0);
endmodule

// File: rtl/split_alu.sv
module split_alu
  import alu_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int SHAMT_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [3:0]         op_i,
  input  logic [1:0]         sel_i,
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  output logic [DATA_W-1:0]  result_o,
  output logic               wr_en_o,
  output logic               zero_o,
  output logic               ovf_o,
  output logic               eq_o
);
  localparam int H = DATA_W / 2;

  logic              byte_mode, hi, known, is_cmp;
  logic [H-1:0]      a_lane, b_lane, res_b;
  logic [DATA_W-1:0] res_w, merged;
  logic              z_w, v_w, z_b, v_b;
  logic [DATA_W-1:0] nxt_res;
  logic              nxt_z, nxt_v;

  assign known     = op_i <= OP_SEXT;
  assign is_cmp    = op_i == OP_CMP;
  assign hi        = sel_i[0];
  assign byte_mode = sel_i[1] && (op_i != OP_SWAB) && (op_i != OP_SEXT);

  alu_byte_pick #(.W(DATA_W)) pick_a_i (.word_i(a_i), .hi_i(hi), .lane_o(a_lane));
  alu_byte_pick #(.W(DATA_W)) pick_b_i (.word_i(b_i), .hi_i(hi), .lane_o(b_lane));

  alu_arith #(.W(DATA_W), .SHW(SHAMT_W)) word_unit_i (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .shamt_i(shamt_i),
    .res_o(res_w), .zero_o(z_w), .ovf_o(v_w)
  );

  alu_arith #(.W(H), .SHW(SHAMT_W)) byte_unit_i (
    .op_i(op_i), .a_i(a_lane), .b_i(b_lane), .shamt_i(shamt_i),
    .res_o(res_b), .zero_o(z_b), .ovf_o(v_b)
  );

  alu_byte_merge #(.W(DATA_W)) merge_i (
    .dest_i(a_i), .lane_i(res_b), .hi_i(hi), .word_o(merged)
  );

  always_comb begin
    if (!known)         nxt_res = '0;
    else if (byte_mode) nxt_res = merged;
    else                nxt_res = res_w;
    nxt_z = known && (byte_mode ? z_b : z_w);
    nxt_v = known && (byte_mode ? v_b : v_w);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      wr_en_o  <= 1'b0;
      zero_o   <= 1'b0;
      ovf_o    <= 1'b0;
      eq_o     <= 1'b0;
    end else begin
      result_o <= nxt_res;
      wr_en_o  <= known && !is_cmp;
      zero_o   <= nxt_z;
      ovf_o    <= nxt_v;
      eq_o     <= is_cmp && nxt_z;
    end
  end
endmodule

// File: rtl/split_alu_chk.sv
module split_alu_chk
  import alu_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int SHAMT_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [3:0]         op_i,
  input logic [1:0]         sel_i,
  input logic [DATA_W-1:0]  a_i,
  input logic [SHAMT_W-1:0] shamt_i,
  input logic [DATA_W-1:0]  result_o,
  input logic               wr_en_o,
  input logic               zero_o,
  input logic               ovf_o,
  input logic               eq_o
);
  localparam int H = DATA_W / 2;

  a_r6_cmp_no_write: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_CMP) |=> !wr_en_o);

  a_r6_eq_implies_zero: assert property (@(posedge clk) disable iff (rst)
    eq_o |-> zero_o);

  a_r3_logic_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR) |=> !ovf_o);

  a_r4_high_keeps_low: assert property (@(posedge clk) disable iff (rst)
    (sel_i == SZ_HIGH && op_i <= OP_SHR) |=> result_o[H-1:0] == $past(a_i[H-1:0]));

  a_r4_low_keeps_high: assert property (@(posedge clk) disable iff (rst)
    (sel_i == SZ_LOW && op_i <= OP_SHR) |=> result_o[DATA_W-1:H] == $past(a_i[DATA_W-1:H]));

  a_r11_unused_quiet: assert property (@(posedge clk) disable iff (rst)
    (op_i > OP_SEXT) |=> (!wr_en_o && !zero_o && !ovf_o && !eq_o && result_o == '0));

  a_r8_far_shift_zero: assert property (@(posedge clk) disable iff (rst)
    ((op_i == OP_SHL || op_i == OP_SHR) && shamt_i >= SHAMT_W'(DATA_W) && !sel_i[1])
      |=> (result_o == '0 && zero_o));
endmodule

bind split_alu split_alu_chk #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) chk_i (
  .clk(clk), .rst(rst), .op_i(op_i), .sel_i(sel_i), .a_i(a_i), .shamt_i(shamt_i),
  .result_o(result_o), .wr_en_o(wr_en_o), .zero_o(zero_o), .ovf_o(ovf_o), .eq_o(eq_o)
);

// File: tb/split_alu_tb_top.sv
module split_alu_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_i = '0;
  logic [1:0]  sel_i = '0;
  logic [15:0] a_i = '0, b_i = '0;
  logic [7:0]  shamt_i = '0;
  logic [15:0] result_o;
  logic        wr_en_o, zero_o, ovf_o, eq_o;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  split_alu dut_i (
    .clk(clk), .rst(rst), .op_i(op_i), .sel_i(sel_i), .a_i(a_i), .b_i(b_i),
    .shamt_i(shamt_i), .result_o(result_o), .wr_en_o(wr_en_o),
    .zero_o(zero_o), .ovf_o(ovf_o), .eq_o(eq_o)
  );

  // codes per R1: 0 add,1 sub,2 and,3 or,4 xor,5 cmp,6 inv,7 shl,8 shr,9 swab,10 sext
  function automatic logic [19:0] model(int op, int sel, int a, int b, int sh);
    int wd, mask, x, y, sx, sy, s, r, full;
    bit bm, hi, v, z;
    if (op > 10) return 20'h0;
    bm = (sel >= 2) && op != 9 && op != 10;
    hi = (sel == 3);
    wd = bm ? 8 : 16;
    mask = (1 << wd) - 1;
    x = bm ? (hi ? (a >> 8) & 255 : a & 255) : a;
    y = bm ? (hi ? (b >> 8) & 255 : b & 255) : b;
    sx = (x >= (1 << (wd - 1))) ? x - (1 << wd) : x;
    sy = (y >= (1 << (wd - 1))) ? y - (1 << wd) : y;
    v = 0;
    r = 0;
    case (op)
      0: begin
        s = sx + sy; r = (x + y) & mask;
        v = (s > (1 << (wd - 1)) - 1) || (s < -(1 << (wd - 1)));
      end
      1, 5: begin
        s = sx - sy; r = (x - y) & mask;
        v = (s > (1 << (wd - 1)) - 1) || (s < -(1 << (wd - 1)));
      end
      2: r = x & y;
      3: r = x | y;
      4: r = x ^ y;
      6: r = ~x & mask;
      7: r = (sh >= wd) ? 0 : (x << sh) & mask;
      8: r = (sh >= wd) ? 0 : x >> sh;
      9: r = ((a & 255) << 8) | (a >> 8);
      10: r = ((a & 128) != 0) ? ((a & 255) | 'hFF00) : (a & 255);
      default: r = 0;
    endcase
    z = (r == 0);
    full = bm ? (hi ? ((r << 8) | (a & 255)) : ((a & 'hFF00) | r)) : r;
    return {full[15:0], op != 5, z, v, (op == 5) && z};
  endfunction

  function automatic string tag(int op, int sel);
    if (sel >= 2 && op <= 8) return "R4/R5";
    case (op)
      0, 1:    return "R2";
      2, 3, 4: return "R3";
      5:       return "R6";
      6:       return "R7";
      7, 8:    return "R8";
      9:       return "R9";
      10:      return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string t, logic [19:0] exp);
    logic [19:0] act;
    act = {result_o, wr_en_o, zero_o, ovf_o, eq_o};
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d sel=%0d a=%h b=%h sh=%0d actual={res,we,z,v,eq}=%h expected=%h",
               t, op_i, sel_i, a_i, b_i, shamt_i, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    logic [15:0] corner [8];
    corner = '{16'h0000, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h0080, 16'h007F, 16'h8080, 16'h7F7F};
    lf = 16'hACE1;
    repeat (3) @(negedge clk);
    check("R12 reset", 20'h0);
    rst = 1'b0;
    for (int oi = 0; oi < 13; oi++) begin
      for (int sel = 0; sel < 4; sel++) begin
        for (int k = 0; k < 40; k++) begin
          int opc;
          opc = (oi < 12) ? oi : 15;
          if (k < 8) begin
            a_i = corner[k];
            b_i = corner[(k + 3) % 8];
          end else begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            a_i = lf;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            b_i = lf;
          end
          if (k % 5 == 0) b_i = a_i;
          if (k % 7 == 3) b_i = {a_i[15:8], ~a_i[7:0]};
          op_i = 4'(opc);
          sel_i = 2'(sel);
          shamt_i = 8'(k % 20);
          @(posedge clk);
          @(negedge clk);
          check(tag(opc, sel), model(opc, sel, int'(a_i), int'(b_i), int'(shamt_i)));
        end
      end
    end
    // R12: reset in the middle of traffic clears every output
    op_i = 4'd0; sel_i = 2'd0; a_i = 16'h0001; b_i = 16'h0001;
    @(posedge clk);
    @(negedge clk);
    check("R12 pre-reset", model(0, 0, 1, 1, 0));
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R12 reset mid-run", 20'h0);
    rst = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule